// File: doc/BRIEF.md
# Indirect Extended-Register Access Bridge

This block sits behind a 32-entry management register port. A frame decoder upstream turns serial management frames into single-cycle read and write strobes with a 5-bit register number. Only registers 0x00 to 0x1F can be reached directly. Any register of the wider, device-addressed space has to be reached in two steps. Software first writes a control word that names the target device space and an access function. It then writes or reads a shared address/data register. Each access through that register either loads the space's address pointer or transfers data at that pointer.

Three device spaces are decoded, and each has its own legal address window and its own pointer. Each space is backed by a small local register array that the pointer indexes by its low bits. An access to a device number that no space claims is refused. So is an access to a pointer outside its space's window. A refused access reads as zero, discards the write, and sets a sticky error flag. The data functions can leave the pointer alone after the transfer, or advance it after reads and writes, or advance it after writes only.

Top module: `mmd_bridge`

## Requirements
- R1: After reset the control word, every space pointer, every backing register and the error flag are zero, and `rd_valid` is low.
- R2: A write to register 0x0D stores bits [15:14] as the function code and bits [4:0] as the device number. A read of 0x0D returns {function[1:0], error flag, 8'b0, device[4:0]}, with bit 13 being the error flag.
- R3: Function code 00 (address mode) applies. A write to register 0x0E loads the selected space's pointer, and a read of 0x0E returns that pointer.
- R4: Function code 01 applies. A write to 0x0E stores into, and a read returns, the register at the selected pointer, and the pointer does not change.
- R5: Function code 10 applies. The selected pointer increases by one after each read and after each write of 0x0E.
- R6: Function code 11 applies. The selected pointer increases by one after each write of 0x0E and is unchanged by reads.
- R7: Each of the three spaces keeps an independent pointer. Device 5'h1F has the window 0x0000 to 0x0DF0, device 5'h01 has 0x1000 to 0x1836, and device 5'h03 has 0x3000 to 0x3001.
- R8: With any other device number, accesses to 0x0E read 0x0000, writes change no stored state, and the error flag is set.
- R9: A data access whose pointer lies outside its space's window reads 0x0000, leaves storage untouched and sets the error flag. The window end points are legal.
- R10: The error flag stays set until reset, and it appears both on `err_flag` and at bit 13 of register 0x0D.
- R11: Read data appears on `rd_data` with `rd_valid` high for exactly the one cycle after the `rd_en` cycle. When `wr_en` and `rd_en` are both high, the write wins and no read is returned.
- R12: Direct registers other than 0x0D and 0x0E read 0x0000, and writes to them change no state.
- R13: An in-window pointer selects backing slot pointer[log2(depth)-1:0]. In the default build the vendor space (depth 16) maps 0x0010 and 0x0000 to the same slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe, one cycle |
| rd_en | input | 1 | Register read strobe, one cycle |
| reg_addr | input | 5 | Direct register number |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Read data, valid with `rd_valid` |
| rd_valid | output | 1 | High one cycle after an accepted read |
| err_flag | output | 1 | Sticky refused-access flag |

## Verification
The hardest cases to reach from the ports are those that need a pointer sitting at a chosen position inside or just outside a window, in one space, while the other spaces hold different pointers. This is hardest when the pointer got there through post-increment and not through a direct load. The stimulus builds these states with address-mode loads, checks them by switching back to address mode and reading the pointer, and places values at aliased slots so that a discarded write would show up as changed data. The sticky flag hides any later errors, so the refusal cases for an unknown device run after a second reset.

// File: rtl/mmd_pkg.sv
package mmd_pkg;

  localparam int unsigned DW         = 16;
  localparam int unsigned NUM_SPACES = 3;

  typedef enum logic [1:0] {
    FN_ADDR   = 2'b00,
    FN_DATA   = 2'b01,
    FN_INC_RW = 2'b10,
    FN_INC_W  = 2'b11
  } fn_e;

  localparam logic [4:0] RA_CTRL = 5'h0D;
  localparam logic [4:0] RA_DATA = 5'h0E;

  function automatic logic [4:0] space_dev(input int idx);
    case (idx)
      0:       return 5'h1F;
      1:       return 5'h01;
      default: return 5'h03;
    endcase
  endfunction

  function automatic logic [DW-1:0] space_lo(input int idx);
    case (idx)
      0:       return 16'h0000;
      1:       return 16'h1000;
      default: return 16'h3000;
    endcase
  endfunction

  function automatic logic [DW-1:0] space_hi(input int idx);
    case (idx)
      0:       return 16'h0DF0;
      1:       return 16'h1836;
      default: return 16'h3001;
    endcase
  endfunction

endpackage

// File: rtl/mmd_ctrl.sv
module mmd_ctrl
  import mmd_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_ctrl,
  input  logic [DW-1:0] wdata,
  input  logic          err_set,
  output fn_e           fn,
  output logic [4:0]    dev,
  output logic          err
);

  fn_e        fn_q, fn_d;
  logic [4:0] dev_q, dev_d;
  logic       err_q, err_d;

  always_comb begin
    fn_d  = fn_q;
    dev_d = dev_q;
    if (wr_ctrl) begin
      fn_d  = fn_e'(wdata[15:14]);
      dev_d = wdata[4:0];
    end
    err_d = err_q | err_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fn_q  <= FN_ADDR;
      dev_q <= '0;
      err_q <= 1'b0;
    end else begin
      fn_q  <= fn_d;
      dev_q <= dev_d;
      err_q <= err_d;
    end
  end

  assign fn  = fn_q;
  assign dev = dev_q;
  assign err = err_q;

  a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);

  a_r2_ctrl_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ctrl |=> (fn_q == $past(fn_q)) && (dev_q == $past(dev_q)));

endmodule

// File: rtl/mmd_space.sv
module mmd_space
  import mmd_pkg::*;
#(
  parameter logic [DW-1:0] WIN_LO = 16'h0000,
  parameter logic [DW-1:0] WIN_HI = 16'h0001,
  parameter int unsigned   DEPTH  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_ptr,
  input  logic [DW-1:0] ptr_in,
  input  logic          wr_acc,
  input  logic          inc,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] ptr,
  output logic [DW-1:0] rdata,
  output logic          in_win
);

  localparam int unsigned   IW   = (DEPTH < 2) ? 1 : $clog2(DEPTH);
  localparam logic [DW-1:0] SPAN = WIN_HI - WIN_LO;

  logic [DW-1:0] ptr_q, ptr_d;
  logic [DW-1:0] mem_q [DEPTH];
  logic [DW-1:0] mem_d [DEPTH];
  logic [IW-1:0] slot;
  logic [DW-1:0] offset;

  assign slot   = ptr_q[IW-1:0];
  assign offset = ptr_q - WIN_LO;
  assign in_win = (offset <= SPAN);

  always_comb begin
    ptr_d = ptr_q;
    if (ld_ptr)   ptr_d = ptr_in;
    else if (inc) ptr_d = ptr_q + 1'b1;
  end

  always_comb begin
    for (int k = 0; k < DEPTH; k++) mem_d[k] = mem_q[k];
    if (wr_acc) mem_d[slot] = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
      for (int k = 0; k < DEPTH; k++) mem_q[k] <= '0;
    end else begin
      ptr_q <= ptr_d;
      for (int k = 0; k < DEPTH; k++) mem_q[k] <= mem_d[k];
    end
  end

  assign ptr   = ptr_q;
  assign rdata = mem_q[slot];

  a_r3_ptr_load: assert property (@(posedge clk) disable iff (!rst_n)
    ld_ptr |=> ptr_q == $past(ptr_in));

  a_r5_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !ld_ptr) |=> ptr_q == $past(ptr_q) + 16'd1);

  a_r4_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc && !ld_ptr) |=> ptr_q == $past(ptr_q));

  a_r9_write_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    wr_acc |-> in_win);

endmodule

// File: rtl/mmd_bridge.sv
module mmd_bridge
  import mmd_pkg::*;
#(
  parameter int unsigned DEPTH_VS = 16,
  parameter int unsigned DEPTH_M1 = 16,
  parameter int unsigned DEPTH_M3 = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [4:0]    reg_addr,
  input  logic [15:0]   wr_data,
  output logic [15:0]   rd_data,
  output logic          rd_valid,
  output logic          err_flag
);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  // access decode
  fn_e        fn;
  logic [4:0] dev;
  logic       err_q;
  logic       rd_acc, acc_wr, acc_rd, data_mode, wr_ctrl;
  logic       any_sel, win_sel, err_set;
  logic [NUM_SPACES-1:0] sel, sp_win, ld_ptr, wr_acc, inc;
  logic [DW-1:0] sp_ptr   [NUM_SPACES];
  logic [DW-1:0] sp_rdata [NUM_SPACES];
  logic [DW-1:0] sel_ptr, sel_rdata;

  assign rd_acc    = rd_en && !wr_en;
  assign acc_wr    = wr_en && (reg_addr == RA_DATA);
  assign acc_rd    = rd_acc && (reg_addr == RA_DATA);
  assign wr_ctrl   = wr_en && (reg_addr == RA_CTRL);
  assign data_mode = (fn != FN_ADDR);

  mmd_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .wr_ctrl (wr_ctrl),
    .wdata   (wr_data),
    .err_set (err_set),
    .fn      (fn),
    .dev     (dev),
    .err     (err_q)
  );

  for (genvar g = 0; g < NUM_SPACES; g++) begin : g_space
    localparam int unsigned DEP = (g == 0) ? DEPTH_VS : (g == 1) ? DEPTH_M1 : DEPTH_M3;

    assign sel[g]    = (dev == space_dev(g));
    assign ld_ptr[g] = acc_wr && !data_mode && sel[g];
    assign wr_acc[g] = acc_wr && data_mode && sel[g] && sp_win[g];
    assign inc[g]    = sel[g] &&
                       ((acc_wr && (fn == FN_INC_RW || fn == FN_INC_W)) ||
                        (acc_rd && (fn == FN_INC_RW)));

    mmd_space #(
      .WIN_LO (space_lo(g)),
      .WIN_HI (space_hi(g)),
      .DEPTH  (DEP)
    ) u_space (
      .clk    (clk),
      .rst_n  (rst_n_s),
      .ld_ptr (ld_ptr[g]),
      .ptr_in (wr_data),
      .wr_acc (wr_acc[g]),
      .inc    (inc[g]),
      .wdata  (wr_data),
      .ptr    (sp_ptr[g]),
      .rdata  (sp_rdata[g]),
      .in_win (sp_win[g])
    );
  end

  always_comb begin
    sel_ptr   = '0;
    sel_rdata = '0;
    for (int k = 0; k < NUM_SPACES; k++) begin
      if (sel[k]) begin
        sel_ptr   = sel_ptr   | sp_ptr[k];
        sel_rdata = sel_rdata | sp_rdata[k];
      end
    end
  end

  assign any_sel = |sel;
  assign win_sel = |(sel & sp_win);
  assign err_set = (acc_wr || acc_rd) && (!any_sel || (data_mode && !win_sel));

  // read path
  logic [DW-1:0] rd_mux, rd_data_q, rd_data_d;
  logic          rd_valid_q, rd_valid_d;

  always_comb begin
    case (reg_addr)
      RA_CTRL: rd_mux = {fn, err_q, 8'h00, dev};
      RA_DATA: begin
        if (data_mode) rd_mux = win_sel ? sel_rdata : '0;
        else           rd_mux = any_sel ? sel_ptr : '0;
      end
      default: rd_mux = '0;
    endcase
  end

  always_comb begin
    rd_data_d  = rd_data_q;
    if (rd_acc) rd_data_d = rd_mux;
    rd_valid_d = rd_acc;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      rd_data_q  <= '0;
      rd_valid_q <= 1'b0;
    end else begin
      rd_data_q  <= rd_data_d;
      rd_valid_q <= rd_valid_d;
    end
  end

  assign rd_data  = rd_data_q;
  assign rd_valid = rd_valid_q;
  assign err_flag = err_q;

  a_r11_valid_follows_read: assert property (@(posedge clk) disable iff (!rst_n_s)
    rd_acc |=> rd_valid);

  a_r11_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n_s)
    !rd_acc |=> !rd_valid);

  a_r8_unknown_dev_reads_zero: assert property (@(posedge clk) disable iff (!rst_n_s)
    (acc_rd && !any_sel) |=> (rd_data == 16'h0000));

  a_r8_unknown_dev_flags: assert property (@(posedge clk) disable iff (!rst_n_s)
    ((acc_wr || acc_rd) && !any_sel) |=> err_flag);

  a_r12_other_reads_zero: assert property (@(posedge clk) disable iff (!rst_n_s)
    (rd_acc && reg_addr != RA_CTRL && reg_addr != RA_DATA) |=> (rd_data == 16'h0000));

  a_r7_one_space_selected: assert property (@(posedge clk) disable iff (!rst_n_s)
    $onehot0(sel));

endmodule

// File: tb/mmd_bridge_tb_top.sv
module mmd_bridge_tb_top;

  logic        clk;
  logic        rst_n;
  logic        wr_en, rd_en;
  logic [4:0]  reg_addr;
  logic [15:0] wr_data;
  logic [15:0] rd_data;
  logic        rd_valid;
  logic        err_flag;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  typedef struct {
    logic [15:0] exp;
    string       tag;
  } exp_t;

  exp_t sb_q[$];

  mmd_bridge dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .reg_addr (reg_addr),
    .wr_data  (wr_data),
    .rd_data  (rd_data),
    .rd_valid (rd_valid),
    .err_flag (err_flag)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops expected items as read results come out
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (sb_q.size() == 0) begin
        check("R11 unexpected rd_valid", 16'h1, 16'h0);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        check(e.tag, rd_data, e.exp);
      end
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; reg_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, input logic [15:0] exp, input string tag);
    exp_t e;
    e.exp = exp; e.tag = tag;
    @(negedge clk);
    sb_q.push_back(e);
    rd_en = 1'b1; reg_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; reg_addr = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    check("R1 rd_valid after reset", {15'b0, rd_valid}, 16'h0);
    check("R1 err_flag after reset", {15'b0, err_flag}, 16'h0);
    rd(5'h0D, 16'h0000, "R1 control word after reset");
    wr(5'h0D, 16'h001F);
    rd(5'h0E, 16'h0000, "R1 vendor pointer after reset");
    wr(5'h0D, 16'h401F);
    rd(5'h0E, 16'h0000, "R1 vendor slot after reset");

    // R2 control register fields
    wr(5'h0D, 16'h7FE1);
    rd(5'h0D, 16'h4001, "R2 control readback masks bits");
    wr(5'h0D, 16'h001F);
    rd(5'h0D, 16'h001F, "R2 control readback");

    // R3 / R4 address and plain data
    wr(5'h0E, 16'h0005);
    rd(5'h0E, 16'h0005, "R3 pointer load");
    wr(5'h0D, 16'h401F);
    wr(5'h0E, 16'hAAAA);
    rd(5'h0E, 16'hAAAA, "R4 data at pointer");
    rd(5'h0E, 16'hAAAA, "R4 repeated read");
    wr(5'h0D, 16'h001F);
    rd(5'h0E, 16'h0005, "R4 pointer unchanged");

    // R5 increment on read and write
    wr(5'h0E, 16'h0010);
    wr(5'h0D, 16'h801F);
    wr(5'h0E, 16'h1111);
    wr(5'h0E, 16'h2222);
    wr(5'h0D, 16'h001F);
    rd(5'h0E, 16'h0012, "R5 pointer after two writes");
    wr(5'h0E, 16'h0010);
    wr(5'h0D, 16'h801F);
    rd(5'h0E, 16'h1111, "R5 first read");
    rd(5'h0E, 16'h2222, "R5 second read");
    wr(5'h0D, 16'h001F);
    rd(5'h0E, 16'h0012, "R5 pointer after two reads");

    // R6 increment on write only
    wr(5'h0E, 16'h0020);
    wr(5'h0D, 16'hC01F);
    wr(5'h0E, 16'h3333);
    rd(5'h0E, 16'h2222, "R6 read after write step");
    rd(5'h0E, 16'h2222, "R6 read does not step");
    wr(5'h0D, 16'h001F);
    rd(5'h0E, 16'h0021, "R6 pointer after write only");

    // R13 aliasing of slot 0
    wr(5'h0E, 16'h0010);
    wr(5'h0D, 16'h401F);
    rd(5'h0E, 16'h3333, "R13 alias 0x0020 and 0x0010");

    // R7 independent pointers
    wr(5'h0D, 16'h0001);
    wr(5'h0E, 16'h1003);
    wr(5'h0D, 16'h4001);
    wr(5'h0E, 16'hBEEF);
    rd(5'h0E, 16'hBEEF, "R7 second space data");
    wr(5'h0D, 16'h001F);
    rd(5'h0E, 16'h0010, "R7 vendor pointer kept");
    wr(5'h0D, 16'h0001);
    rd(5'h0E, 16'h1003, "R7 second pointer kept");
    wr(5'h0D, 16'h0003);
    wr(5'h0E, 16'h3001);
    wr(5'h0D, 16'h4003);
    wr(5'h0E, 16'h1234);
    rd(5'h0E, 16'h1234, "R9 third space upper end");
    wr(5'h0D, 16'h001F);
    wr(5'h0E, 16'h0DF0);
    wr(5'h0D, 16'h401F);
    wr(5'h0E, 16'h5555);
    rd(5'h0E, 16'h5555, "R9 vendor upper end");
    @(negedge clk);
    check("R9 no error at window ends", {15'b0, err_flag}, 16'h0);

    // R9 outside window
    wr(5'h0D, 16'h001F);
    wr(5'h0E, 16'h0DF1);
    wr(5'h0D, 16'h401F);
    wr(5'h0E, 16'h9999);
    rd(5'h0E, 16'h0000, "R9 outside window reads zero");
    @(negedge clk);
    check("R9 error flag", {15'b0, err_flag}, 16'h1);
    wr(5'h0D, 16'h001F);
    wr(5'h0E, 16'h0011);
    wr(5'h0D, 16'h401F);
    rd(5'h0E, 16'h2222, "R9 aliased slot untouched");
    rd(5'h0D, 16'h601F, "R10 error bit in control");
    @(negedge clk);
    check("R10 flag stays set", {15'b0, err_flag}, 16'h1);

    // R11 write wins over read
    @(negedge clk);
    wr_en = 1'b1; rd_en = 1'b1; reg_addr = 5'h05; wr_data = 16'h0;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    check("R11 no valid when write wins", {15'b0, rd_valid}, 16'h0);

    // R8 unknown device after fresh reset
    do_reset();
    check("R1 err_flag after second reset", {15'b0, err_flag}, 16'h0);
    wr(5'h0D, 16'h001F);
    wr(5'h0E, 16'h0011);
    wr(5'h0D, 16'h401F);
    rd(5'h0E, 16'h0000, "R1 storage cleared by reset");
    wr(5'h0D, 16'h4002);
    wr(5'h0E, 16'h7777);
    rd(5'h0E, 16'h0000, "R8 unknown device reads zero");
    @(negedge clk);
    check("R8 error flag", {15'b0, err_flag}, 16'h1);
    wr(5'h0D, 16'h0001);
    wr(5'h0E, 16'h1003);
    wr(5'h0D, 16'h4001);
    rd(5'h0E, 16'h0000, "R8 other space untouched");

    // R12 other direct registers
    wr(5'h05, 16'hFFFF);
    rd(5'h05, 16'h0000, "R12 direct register reads zero");
    rd(5'h1F, 16'h0000, "R12 top direct register");
    rd(5'h0D, 16'h6001, "R12 control unchanged");

    repeat (4) @(negedge clk);
    check("R11 scoreboard drained", 16'(sb_q.size()), 16'h0);
    finish_run();
  end

endmodule